// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port

This block is a full-duplex asynchronous serial transmitter and receiver pair. A small configuration register selects how the two halves reach the outside world: two separate pins, an internal loop-back where the transmitter feeds the receiver, or a single-wire half-duplex mode where one pin with a tristate enable carries both directions. The same register selects 8- or 9-bit characters, hardware parity (which replaces the top bit of the character rather than adding a bit), odd or even parity, and when idle-line counting begins.

A host loads a character through a parallel strobe and reads each received character on a one-cycle valid pulse, together with parity-error and framing-error flags. A separate one-cycle pulse reports that the receive line has stayed high for a full character time after activity. A divisor input sets the rate of a tick that runs at 16 times the bit rate; the receiver takes three samples around the middle of each bit and keeps the majority.

Top module: `async_serial_port`

## Requirements
- R1: After reset the configuration reads as zero (two-pin mode, 8-bit, parity off, idle counted from the start bit, even parity), `txd_o` is 1, `txd_oe` is 1, `tx_busy` is 0, and no receive or idle pulse occurs.
- R2: In two-pin mode (configuration bit 5 = 0) a loaded character leaves on `txd_o` as one start bit of 0, the data bits least significant first, then a stop bit of 1, each bit 16 ticks long; characters arriving on `rxd_i` are received.
- R3: With bit 5 = 1 and bit 4 = 0 the transmitter output feeds the receiver internally and `rxd_i` is ignored, even when held low.
- R4: With bit 5 = 1 and bit 4 = 1 (single-wire), `txd_oe` is 1 only while a frame is being sent; the receiver listens to `txd_i`, so it receives its own frames and frames another device drives while the pin is released.
- R5: Bit 4 has no effect while bit 5 is 0: the receiver still takes `rxd_i` and `txd_oe` stays 1.
- R6: With bit 3 = 1 characters have 9 data bits; the ninth is sent after the eighth and before the stop bit, and `rx_data[8]` holds it. With bit 3 = 0, `rx_data[8]` reads 0.
- R7: With bit 1 = 1 the transmitter replaces the character's top bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) with a parity bit so that the count of ones in the character is even when bit 0 = 0 and odd when bit 0 = 1.
- R8: With bit 1 = 1 the receiver raises `rx_perr` with `rx_valid` when the received character's count of ones does not match the selected parity; with bit 1 = 0 `rx_perr` stays 0.
- R9: A stop bit sampled as 0 raises `rx_ferr` with `rx_valid`; a stop bit of 1 leaves it 0.
- R10: `rx_idle` pulses for one cycle once the line has stayed high for 160 ticks in 8-bit mode or 176 ticks in 9-bit mode after a start bit was seen, and only once per period of activity.
- R11: With bit 2 = 0 the idle count runs from the end of the start bit, so trailing 1 data bits and the stop bit count; with bit 2 = 1 it begins only after the stop bit has been sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | DIV_W | Clocks per oversampling tick (0 treated as 1) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | [5] loop, [4] wire source, [3] 9-bit, [2] idle after stop, [1] parity on, [0] odd parity |
| cfg_q | output | 6 | Current configuration |
| tx_load | input | 1 | Load a character when the transmitter is free |
| tx_data | input | 9 | Character to send |
| tx_busy | output | 1 | Frame in progress |
| rx_valid | output | 1 | One-cycle pulse with a received character |
| rx_data | output | 9 | Received character including any parity bit |
| rx_perr | output | 1 | Parity mismatch, valid with rx_valid |
| rx_ferr | output | 1 | Stop bit low, valid with rx_valid |
| rx_idle | output | 1 | One-cycle idle-line pulse |
| rxd_i | input | 1 | Receive pin |
| txd_i | input | 1 | Level seen on the transmit pin |
| txd_o | output | 1 | Transmit pin drive value |
| txd_oe | output | 1 | Transmit pin drive enable |

## Verification
The bench holds `rxd_i` low during internal loop-back, where a design that still listened to the pin would see a break and report a stray character or framing error. It drives frames onto the released single-wire pin and onto `rxd_i` with the wire-source bit set in two-pin mode, catching routing that ignores the mode decode. It samples transmitted frames bit by bit to catch parity that is appended instead of replacing the top bit, or the ninth bit put in the wrong place, and measures the gap from the stop-bit sample to the idle pulse in both idle types and both character lengths, where a miscounted window or a wrong start point shifts the pulse by many bit times. Random characters under random length and parity settings go through loop-back, along with wrong-parity and low-stop frames.

// File: rtl/asp_pkg.sv
package asp_pkg;

   localparam int CFG_W = 6;

   // bit 5 down to bit 0
   typedef struct packed {
      logic loop_en;
      logic wire_src;
      logic nine_bit;
      logic idle_post;
      logic par_en;
      logic par_odd;
   } asp_cfg_t;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } asp_rx_state_e;

   // Character as it goes on the line: top bit replaced when parity is on.
   function automatic logic [8:0] asp_line_char(input logic [8:0] raw,
                                                input logic nine,
                                                input logic en,
                                                input logic odd);
      logic [8:0] c;
      c = nine ? raw : {1'b0, raw[7:0]};
      if (en) begin
         if (nine) c[8] = (^c[7:0]) ^ odd;
         else      c[7] = (^c[6:0]) ^ odd;
      end
      return c;
   endfunction

endpackage

// File: rtl/asp_tick_gen.sv
module asp_tick_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W:0]   nxt;

   assign nxt = {1'b0, cnt} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (nxt >= {1'b0, div}) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= nxt[DIV_W-1:0];
         tick <= 1'b0;
      end
   end
endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       nine_bit,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       load,
   input  logic [8:0] data,
   output logic       line,
   output logic       busy
);
   import asp_pkg::*;

   localparam int SUB_W   = $clog2(OVS);
   localparam int FRAME_W = 11;
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

   logic [FRAME_W-1:0] shreg;
   logic [FRAME_W-1:0] frame;
   logic [8:0]         chr;
   logic [SUB_W-1:0]   sub;
   logic [3:0]         left;

   always_comb begin
      chr   = asp_line_char(data, nine_bit, par_en, par_odd);
      frame = nine_bit ? {1'b1, chr, 1'b0} : {2'b11, chr[7:0], 1'b0};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         shreg <= '1;
         sub   <= '0;
         left  <= '0;
      end else if (load && !busy) begin
         shreg <= frame;
         left  <= nine_bit ? 4'd11 : 4'd10;
         sub   <= '0;
         busy  <= 1'b1;
      end else if (busy && tick) begin
         if (sub == SUB_LAST) begin
            sub   <= '0;
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - 4'd1;
            if (left == 4'd1) busy <= 1'b0;
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end

   assign line = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/asp_rx.sv
module asp_rx #(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       line_in,
   input  logic       nine_bit,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       idle_post,
   output logic       valid,
   output logic [8:0] data,
   output logic       perr,
   output logic       ferr,
   output logic       idle_pulse
);
   import asp_pkg::*;

   localparam int SUB_W  = $clog2(OVS);
   localparam int IDLE_W = $clog2(OVS * 11 + 1);
   localparam logic [SUB_W-1:0]  SMP_A    = SUB_W'(OVS / 2 - 1);
   localparam logic [SUB_W-1:0]  SMP_B    = SUB_W'(OVS / 2);
   localparam logic [SUB_W-1:0]  SMP_C    = SUB_W'(OVS / 2 + 1);
   localparam logic [SUB_W-1:0]  SUB_LAST = SUB_W'(OVS - 1);
   localparam logic [IDLE_W-1:0] IDLE_8   = IDLE_W'(OVS * 10);
   localparam logic [IDLE_W-1:0] IDLE_9   = IDLE_W'(OVS * 11);

   logic ln;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b1;
            else        q <= line_in;
         end
         assign ln = q;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '1;
            else        q <= {q[SYNC_STAGES-2:0], line_in};
         end
         assign ln = q[SYNC_STAGES-1];
      end
   endgenerate

   asp_rx_state_e     st;
   logic [SUB_W-1:0]  sub;
   logic [3:0]        bidx;
   logic [8:0]        sh;
   logic              s_a, s_b, maj;
   logic [8:0]        chr;
   logic [3:0]        last_bit;
   logic [IDLE_W-1:0] idle_cnt, idle_lim;
   logic              armed;

   always_comb begin
      maj      = (s_a & s_b) | (s_a & ln) | (s_b & ln);
      chr      = nine_bit ? sh : {1'b0, sh[8:1]};
      last_bit = nine_bit ? 4'd8 : 4'd7;
      idle_lim = nine_bit ? IDLE_9 : IDLE_8;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= RX_IDLE;
         sub        <= '0;
         bidx       <= '0;
         sh         <= '0;
         s_a        <= 1'b1;
         s_b        <= 1'b1;
         valid      <= 1'b0;
         data       <= '0;
         perr       <= 1'b0;
         ferr       <= 1'b0;
         idle_cnt   <= '0;
         armed      <= 1'b0;
         idle_pulse <= 1'b0;
      end else begin
         valid      <= 1'b0;
         idle_pulse <= 1'b0;
         if (tick) begin
            if (!ln)
               idle_cnt <= '0;
            else if ((!idle_post || st == RX_IDLE) && idle_cnt != idle_lim)
               idle_cnt <= idle_cnt + 1'b1;
            if (armed && idle_cnt == idle_lim) begin
               idle_pulse <= 1'b1;
               armed      <= 1'b0;
            end
            if (st == RX_IDLE) begin
               if (!ln) begin
                  st    <= RX_START;
                  sub   <= '0;
                  armed <= 1'b1;
               end
            end else begin
               sub <= sub + 1'b1;
               if (sub == SMP_A) s_a <= ln;
               if (sub == SMP_B) s_b <= ln;
               if (sub == SMP_C) begin
                  case (st)
                     RX_START: if (maj) st <= RX_IDLE;
                     RX_DATA:  sh <= {maj, sh[8:1]};
                     RX_STOP: begin
                        st    <= RX_IDLE;
                        valid <= 1'b1;
                        data  <= chr;
                        ferr  <= !maj;
                        perr  <= par_en & ((^chr) ^ par_odd);
                     end
                     default: ;
                  endcase
               end
               if (sub == SUB_LAST) begin
                  if (st == RX_START) begin
                     st   <= RX_DATA;
                     bidx <= '0;
                  end else if (st == RX_DATA) begin
                     bidx <= bidx + 4'd1;
                     if (bidx == last_bit) st <= RX_STOP;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port #(
   parameter int DIV_W       = 16,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] baud_div,
   input  logic             cfg_we,
   input  logic [5:0]       cfg_wdata,
   output logic [5:0]       cfg_q,
   input  logic             tx_load,
   input  logic [8:0]       tx_data,
   output logic             tx_busy,
   output logic             rx_valid,
   output logic [8:0]       rx_data,
   output logic             rx_perr,
   output logic             rx_ferr,
   output logic             rx_idle,
   input  logic             rxd_i,
   input  logic             txd_i,
   output logic             txd_o,
   output logic             txd_oe
);
   import asp_pkg::*;

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
      if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two and at least 8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   asp_cfg_t cfg;
   logic     tick, tx_line, rx_line;

   always_ff @(posedge clk) begin
      if (!rst_n)      cfg <= '0;
      else if (cfg_we) cfg <= asp_cfg_t'(cfg_wdata);
   end
   assign cfg_q = cfg;

   asp_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
   );

   asp_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .nine_bit(cfg.nine_bit), .par_en(cfg.par_en), .par_odd(cfg.par_odd),
      .load(tx_load), .data(tx_data), .line(tx_line), .busy(tx_busy)
   );

   always_comb begin
      if (!cfg.loop_en)      rx_line = rxd_i;
      else if (cfg.wire_src) rx_line = txd_i;
      else                   rx_line = tx_line;
   end

   assign txd_o  = tx_line;
   assign txd_oe = !(cfg.loop_en && cfg.wire_src) || tx_busy;

   asp_rx #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(rx_line),
      .nine_bit(cfg.nine_bit), .par_en(cfg.par_en), .par_odd(cfg.par_odd),
      .idle_post(cfg.idle_post),
      .valid(rx_valid), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr),
      .idle_pulse(rx_idle)
   );
endmodule

// File: rtl/async_serial_port_chk.sv
module async_serial_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [5:0] cfg_q,
   input logic       tx_load,
   input logic       tx_busy,
   input logic       txd_o,
   input logic       txd_oe,
   input logic       rx_valid,
   input logic       rx_perr,
   input logic       rx_idle
);
   // R1
   line_high_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd_o);

   // R2
   load_begins_start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && !tx_busy) |=> (tx_busy && !txd_o));

   // R4
   wire_released_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[5] && cfg_q[4] && !tx_busy) |-> !txd_oe);

   // R5
   two_pin_always_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[5] |-> txd_oe);

   // R8
   no_perr_without_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !$past(cfg_q[1])) |-> !rx_perr);

   // R10
   idle_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_idle |=> !rx_idle);
endmodule

bind async_serial_port async_serial_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .tx_load(tx_load),
   .tx_busy(tx_busy), .txd_o(txd_o), .txd_oe(txd_oe),
   .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_idle(rx_idle)
);

// File: tb/async_serial_port_test.sv
module async_serial_port_test;
   localparam int DIV = 4;
   localparam int BITC = 16 * DIV;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic [15:0] baud_div = 16'(DIV);
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_wdata = '0;
   logic [5:0]  cfg_q;
   logic        tx_load = 1'b0;
   logic [8:0]  tx_data = '0;
   logic        tx_busy, rx_valid, rx_perr, rx_ferr, rx_idle;
   logic [8:0]  rx_data;
   logic        bench_rxd = 1'b1, sw_drv = 1'b1;
   logic        txd_i, txd_o, txd_oe;

   assign txd_i = txd_oe ? txd_o : sw_drv;

   async_serial_port uut (
      .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .tx_load(tx_load), .tx_data(tx_data),
      .tx_busy(tx_busy), .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
      .rx_ferr(rx_ferr), .rx_idle(rx_idle), .rxd_i(rxd_i_w), .txd_i(txd_i),
      .txd_o(txd_o), .txd_oe(txd_oe)
   );
   logic rxd_i_w;
   assign rxd_i_w = bench_rxd;

   int total = 0, bad = 0;
   int cyc = 0, rx_count = 0, idle_count = 0, t_valid = 0, t_idle = 0;
   logic [8:0] cap_data;
   logic cap_perr, cap_ferr;

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      if (rx_valid) begin
         cap_data = rx_data; cap_perr = rx_perr; cap_ferr = rx_ferr;
         rx_count = rx_count + 1; t_valid = cyc;
      end
      if (rx_idle) begin
         idle_count = idle_count + 1; t_idle = cyc;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] exp_char(input logic [8:0] ch, input logic nine,
                                           input logic pe, input logic odd);
      logic [8:0] c;
      int ones;
      c = nine ? ch : {1'b0, ch[7:0]};
      if (pe) begin
         ones = 0;
         for (int i = 0; i < (nine ? 8 : 7); i++) ones += c[i];
         if (nine) c[8] = ((ones % 2) == 1) ^ odd;
         else      c[7] = ((ones % 2) == 1) ^ odd;
      end
      return c;
   endfunction

   task automatic set_cfg(input logic [5:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic tx_send(input logic [8:0] ch);
      @(negedge clk);
      while (tx_busy) @(negedge clk);
      tx_data = ch; tx_load = 1'b1;
      @(negedge clk); tx_load = 1'b0;
   endtask

   task automatic tx_capture(input int nb, output logic [10:0] bits);
      int guard = 0;
      bits = '1;
      while (txd_o !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
      repeat (BITC / 2) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         bits[i] = txd_o;
         repeat (BITC) @(negedge clk);
      end
   endtask

   task automatic drive_frame(input logic [8:0] ch, input int nd, input logic stopv,
                              input bit on_wire);
      logic [10:0] f;
      f = '1;
      f[0] = 1'b0;
      for (int i = 0; i < nd; i++) f[i + 1] = ch[i];
      f[nd + 1] = stopv;
      for (int i = 0; i < nd + 2; i++) begin
         @(negedge clk);
         if (on_wire) sw_drv = f[i]; else bench_rxd = f[i];
         repeat (BITC - 1) @(negedge clk);
      end
      @(negedge clk);
      if (on_wire) sw_drv = 1'b1; else bench_rxd = 1'b1;
   endtask

   task automatic wait_rx(input int prev);
      int guard = 0;
      while (rx_count == prev && guard < 3000) begin @(negedge clk); guard++; end
   endtask

   initial begin
      #(20 * 190000);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [10:0] bits;
      int prev, pidle, delta;
      void'($urandom(32'h5eed));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);

      // R1 reset state
      chk("R1 cfg", cfg_q, 6'h00);
      chk("R1 txd_o", txd_o, 1);
      chk("R1 txd_oe", txd_oe, 1);
      chk("R1 busy", tx_busy, 0);
      chk("R1 no rx", rx_count, 0);
      chk("R1 no idle", idle_count, 0);

      // R2 two-pin frame on txd_o
      tx_send(9'h0A5); tx_capture(10, bits);
      chk("R2 tx frame", bits[9:0], {1'b1, 8'hA5, 1'b0});

      // R6 nine-bit frame
      set_cfg(6'b001000);
      tx_send(9'h1A5); tx_capture(11, bits);
      chk("R6 tx 9-bit frame", bits, {1'b1, 9'h1A5, 1'b0});

      // R7 parity generation, 8-bit even then odd
      set_cfg(6'b000010);
      tx_send(9'h001); tx_capture(10, bits);
      chk("R7 even parity bit7", bits[8], 1);
      set_cfg(6'b000011);
      tx_send(9'h0FF); tx_capture(10, bits);
      chk("R7 odd parity bit7", bits[8:1], 8'h7F);

      // R2 receive from rxd_i
      set_cfg(6'b000000);
      repeat (200) @(negedge clk);
      prev = rx_count;
      drive_frame(9'h03C, 8, 1'b1, 0); wait_rx(prev);
      chk("R2 rx data", cap_data, 9'h03C);
      chk("R9 stop ok no ferr", cap_ferr, 0);
      chk("R6 8-bit top zero", cap_data[8], 0);

      // R5 wire source ignored in two-pin mode
      set_cfg(6'b010000);
      chk("R5 oe held", txd_oe, 1);
      prev = rx_count;
      drive_frame(9'h05A, 8, 1'b1, 0); wait_rx(prev);
      chk("R5 rx from rxd_i", cap_data, 9'h05A);

      // R3 internal loop-back ignores rxd_i held low
      set_cfg(6'b100000);
      bench_rxd = 1'b0;
      repeat (200) @(negedge clk);
      prev = rx_count;
      tx_send(9'h0C3); wait_rx(prev);
      chk("R3 loop data", cap_data, 9'h0C3);
      repeat (1500) @(negedge clk);
      chk("R3 single char", rx_count, prev + 1);
      set_cfg(6'b000000);
      bench_rxd = 1'b1;
      repeat (1500) @(negedge clk);

      // R4 single-wire
      set_cfg(6'b110000);
      repeat (4) @(negedge clk);
      chk("R4 released when free", txd_oe, 0);
      prev = rx_count;
      tx_send(9'h096);
      repeat (BITC * 3) @(negedge clk);
      chk("R4 driven in frame", txd_oe, 1);
      wait_rx(prev);
      chk("R4 own frame", cap_data, 9'h096);
      repeat (200) @(negedge clk);
      prev = rx_count;
      drive_frame(9'h069, 8, 1'b1, 1); wait_rx(prev);
      chk("R4 external frame", cap_data, 9'h069);

      // R8 parity check, 8-bit even and 9-bit odd
      set_cfg(6'b000010);
      repeat (1500) @(negedge clk);
      prev = rx_count;
      drive_frame(9'h083, 8, 1'b1, 0); wait_rx(prev);
      chk("R8 bad even parity", cap_perr, 1);
      prev = rx_count;
      drive_frame(9'h003, 8, 1'b1, 0); wait_rx(prev);
      chk("R8 good even parity", cap_perr, 0);
      set_cfg(6'b001011);
      prev = rx_count;
      drive_frame(9'h101, 9, 1'b1, 0); wait_rx(prev);
      chk("R8 bad odd parity", cap_perr, 1);
      chk("R6 ninth bit rx", cap_data, 9'h101);
      prev = rx_count;
      drive_frame(9'h001, 9, 1'b1, 0); wait_rx(prev);
      chk("R8 good odd parity", cap_perr, 0);

      // R9 framing error
      set_cfg(6'b000000);
      prev = rx_count;
      drive_frame(9'h055, 8, 1'b0, 0); wait_rx(prev);
      chk("R9 ferr", cap_ferr, 1);
      repeat (1500) @(negedge clk);

      // R10 / R11 idle after stop, 8-bit and 9-bit
      set_cfg(6'b000100);
      pidle = idle_count; prev = rx_count;
      drive_frame(9'h055, 8, 1'b1, 0); wait_rx(prev);
      repeat (1000) @(negedge clk);
      delta = t_idle - t_valid;
      chk("R10 one idle pulse", idle_count, pidle + 1);
      chk("R11 idle after stop 8-bit window", (delta > 600 && delta < 690), 1);
      set_cfg(6'b001100);
      pidle = idle_count; prev = rx_count;
      drive_frame(9'h155, 9, 1'b1, 0); wait_rx(prev);
      repeat (1000) @(negedge clk);
      delta = t_idle - t_valid;
      chk("R10 idle 9-bit window", (delta > 664 && delta < 754), 1);
      // R11 idle from start bit
      set_cfg(6'b000000);
      pidle = idle_count; prev = rx_count;
      drive_frame(9'h0FF, 8, 1'b1, 0); wait_rx(prev);
      repeat (1000) @(negedge clk);
      delta = t_idle - t_valid;
      chk("R11 idle from start bit", (delta > 40 && delta < 200), 1);
      chk("R10 once per activity", idle_count, pidle + 1);

      // random characters through loop-back (R3 R6 R7 R8)
      for (int n = 0; n < 30; n++) begin
         logic [8:0] ch;
         logic nine, pe, odd;
         nine = $urandom % 2; pe = $urandom % 2; odd = $urandom % 2;
         ch = 9'($urandom);
         set_cfg({2'b10, nine, 1'b0, pe, odd});
         prev = rx_count;
         tx_send(ch); wait_rx(prev);
         chk("R7 random loop char", cap_data, exp_char(ch, nine, pe, odd));
         chk("R8 random no perr", cap_perr, 0);
         chk("R9 random no ferr", cap_ferr, 0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule